// File: doc/BRIEF.md
# Floating-Point to Integer Converter

This block turns a packed single-precision floating-point operand into a 32-bit integer, either two's-complement signed or unsigned. The caller selects one of four rounding directions for each conversion. A separate truncate control forces rounding toward zero regardless of the selected direction. Values that do not fit saturate to a fixed limit for the chosen signedness, and NaN inputs give a fixed result.

Each conversion is a single-cycle request qualified by `in_valid`. The integer and three status flags (invalid operation, inexact, denormal input) are registered and appear one clock later with `out_valid`. The result and flag registers keep their last value until the next accepted request. The converter does not go the other way, from integer to float.

Top module: `fti_convert`

## Requirements
- R1: A request taken with `in_valid` high on a rising clock edge updates `result` and the three flags on that edge. `out_valid` is high for exactly the cycle that follows each request and low otherwise.
- R2: An operand with a zero exponent field and a non-zero fraction sets `flag_denorm`. Every other operand clears it.
- R3: The operand's sign is bit 31, its biased exponent is bits 30:23 and its fraction is bits 22:0. For a non-NaN operand with a biased exponent of 159 or more, including infinities, the converter raises invalid. The result is then 0x7FFFFFFF (signed, positive), 0x80000000 (signed, negative), 0xFFFFFFFF (unsigned, positive) or 0 (unsigned, negative).
- R4: A NaN gives 0 with invalid in signed mode. In unsigned mode a NaN of either sign gives 0xFFFFFFFF with invalid.
- R5: Round-to-nearest (mode 0) rounds an exact half toward the even integer.
- R6: The mode encoding is 0 nearest, 1 toward +infinity, 2 toward -infinity, 3 toward zero. Each directed mode moves a non-integer value in its own direction, for both signs.
- R7: With `force_trunc` high the converter rounds toward zero, whatever `round_mode` holds.
- R8: An unsigned conversion of a negative value whose rounded magnitude is non-zero returns 0 with invalid and without inexact. A negative value that rounds to zero returns 0 without invalid.
- R9: A signed conversion whose rounded magnitude exceeds 0x7FFFFFFF (positive) or 0x80000000 (negative) saturates to that limit with invalid. -2^31 converts exactly with no flag.
- R10: In range, inexact is set exactly when the discarded fraction is non-zero. An integral value converts with no flag.
- R11: A non-zero magnitude below 0.5 always sets inexact. It gives 1 when rounding toward +infinity on a positive value. When rounding toward -infinity on a negative value it gives -1 (signed) or 0 with invalid (unsigned). In all other cases it gives 0.
- R12: Positive and negative zero convert to 0 with no flags set.
- R13: During and after reset, `out_valid`, `result` and all three flags are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Conversion request |
| operand | input | 32 | Packed single-precision operand |
| is_signed | input | 1 | 1: signed result, 0: unsigned result |
| round_mode | input | 2 | Rounding direction (0 nearest, 1 +inf, 2 -inf, 3 zero) |
| force_trunc | input | 1 | Forces round-toward-zero |
| out_valid | output | 1 | Result registers updated in the previous cycle |
| result | output | 32 | Converted integer |
| flag_invalid | output | 1 | Invalid operation |
| flag_inexact | output | 1 | Result differs from the operand |
| flag_denorm | output | 1 | Operand was denormal |

## Verification
Some properties are checked on every request: the one-cycle timing of `out_valid`, the denormal flag, the zero result for NaN in signed mode and for negative operands in unsigned mode, the clean result for zero operands, and that a signed invalid result is always one of the three legal values. Tie-to-even rounding, the direction taken by each directed mode, the truncate override, and the exact boundaries of saturation and sub-half magnitudes depend on arithmetic results. Only the bench can show those, by comparing against its own model over directed corner operands and a large set of random operands clustered around the integer range.

// File: rtl/fti_pkg.sv
`timescale 1ns/1ps
package fti_pkg;

   typedef enum logic [1:0] {
      RND_NEAREST = 2'd0,
      RND_UP      = 2'd1,
      RND_DOWN    = 2'd2,
      RND_ZERO    = 2'd3
   } rnd_mode_e;

endpackage

// File: rtl/fti_classify.sv
`timescale 1ns/1ps
module fti_classify #(
   parameter int EXP_W  = 8,
   parameter int FRAC_W = 23
) (
   input  logic [EXP_W+FRAC_W:0] operand,
   output logic                  sign,
   output logic [EXP_W-1:0]      exp_f,
   output logic [FRAC_W:0]       mant,
   output logic                  is_nan,
   output logic                  is_zero,
   output logic                  is_denorm
);
   localparam int FP_W = 1 + EXP_W + FRAC_W;

   logic [FRAC_W-1:0] frac;
   logic              exp_zero;
   logic              exp_ones;
   logic              frac_nz;

   assign sign      = operand[FP_W-1];
   assign exp_f     = operand[FP_W-2:FRAC_W];
   assign frac      = operand[FRAC_W-1:0];
   assign exp_zero  = ~|exp_f;
   assign exp_ones  = &exp_f;
   assign frac_nz   = |frac;

   assign is_nan    = exp_ones & frac_nz;
   assign is_zero   = exp_zero & ~frac_nz;
   assign is_denorm = exp_zero & frac_nz;
   // hidden bit present for every non-zero exponent
   assign mant      = {~exp_zero, frac};
endmodule

// File: rtl/fti_align.sv
`timescale 1ns/1ps
module fti_align #(
   parameter int INT_W  = 32,
   parameter int EXP_W  = 8,
   parameter int FRAC_W = 23
) (
   input  logic [EXP_W-1:0]  exp_f,
   input  logic [FRAC_W:0]   mant,
   output logic              tiny,
   output logic              big,
   output logic [INT_W-1:0]  int_part,
   output logic [INT_W-1:0]  rem
);
   localparam int BIAS = (1 << (EXP_W - 1)) - 1;
   localparam int LO_E = BIAS - 1;
   localparam int HI_E = BIAS + INT_W;
   localparam int EW   = EXP_W + 1;
   localparam int SW   = $clog2(INT_W + 1);
   localparam int PAD  = INT_W - 1 - FRAC_W;
   localparam int WW   = 2 * INT_W;

   if (PAD < 1) begin : g_bad_width
      $error("fti_align: INT_W must exceed FRAC_W+1");
   end
   if (HI_E >= (1 << EXP_W) - 1) begin : g_bad_range
      $error("fti_align: integer range must lie below the special exponent");
   end
   if (SW > EW) begin : g_bad_shift
      $error("fti_align: shift amount wider than exponent");
   end

   logic [EW-1:0] e_ext;
   logic [SW-1:0] sh;

   assign e_ext = {1'b0, exp_f};
   assign tiny  = e_ext < EW'(LO_E);
   assign big   = e_ext >= EW'(HI_E);
   // distance from the exponent at which the leading bit is the integer MSB
   assign sh    = SW'(EW'(HI_E - 1) - e_ext);

   logic [WW-1:0] stg [SW+1];
   assign stg[0] = {mant, {PAD{1'b0}}, {INT_W{1'b0}}};

   for (genvar k = 0; k < SW; k++) begin : g_stage
      assign stg[k+1] = sh[k] ? (stg[k] >> (1 << k)) : stg[k];
   end

   assign int_part = stg[SW][WW-1:INT_W];
   assign rem      = stg[SW][INT_W-1:0];
endmodule

// File: rtl/fti_round.sv
`timescale 1ns/1ps
module fti_round
   import fti_pkg::*;
#(
   parameter int INT_W        = 32,
   parameter bit CARRY_BY_ADD = 1'b1
) (
   input  logic [INT_W-1:0] rem,
   input  logic             int_lsb,
   input  logic             sign,
   input  rnd_mode_e        mode,
   output logic             round_up,
   output logic             rem_nz
);
   localparam logic [INT_W-1:0] HALF = {1'b1, {(INT_W-1){1'b0}}};
   localparam logic [INT_W-1:0] ONES = {INT_W{1'b1}};

   logic [INT_W-1:0] incr;

   always_comb begin
      case (mode)
         RND_NEAREST: incr = int_lsb ? HALF : (HALF - 1'b1);
         RND_UP:      incr = sign ? '0 : ONES;
         RND_DOWN:    incr = sign ? ONES : '0;
         default:     incr = '0;
      endcase
   end

   if (CARRY_BY_ADD) begin : g_carry_add
      assign round_up = (({1'b0, rem} + {1'b0, incr}) >= {1'b1, {INT_W{1'b0}}});
   end else begin : g_carry_cmp
      assign round_up = rem > ~incr;
   end

   assign rem_nz = |rem;
endmodule

// File: rtl/fti_resolve.sv
`timescale 1ns/1ps
module fti_resolve
   import fti_pkg::*;
#(
   parameter int INT_W = 32
) (
   input  logic             sign,
   input  logic             is_nan,
   input  logic             is_zero,
   input  logic             is_signed,
   input  logic             tiny,
   input  logic             big,
   input  rnd_mode_e        mode,
   input  logic [INT_W-1:0] int_part,
   input  logic             round_up,
   input  logic             rem_nz,
   output logic [INT_W-1:0] res,
   output logic             inv,
   output logic             inx
);
   localparam logic [INT_W-1:0] ONES = {INT_W{1'b1}};
   localparam logic [INT_W-1:0] SMAX = {1'b0, {(INT_W-1){1'b1}}};
   localparam logic [INT_W-1:0] SMIN = {1'b1, {(INT_W-1){1'b0}}};

   logic             at_max;
   logic [INT_W-1:0] mag;
   logic [INT_W-1:0] lim;
   logic [INT_W-1:0] sel;
   logic             tiny_up;
   logic             tiny_dn;

   assign at_max  = int_part == ONES;
   assign mag     = int_part + INT_W'(round_up & ~at_max);
   assign lim     = sign ? SMIN : SMAX;
   assign tiny_up = (mode == RND_UP) & ~sign;
   assign tiny_dn = (mode == RND_DOWN) & sign;

   always_comb begin
      res = '0;
      inv = 1'b0;
      inx = 1'b0;
      sel = '0;
      if (!is_signed) begin
         if (is_nan) begin
            res = ONES;
            inv = 1'b1;
         end else if (big) begin
            res = sign ? '0 : ONES;
            inv = 1'b1;
         end else if (!tiny) begin
            if (round_up && at_max) inv = 1'b1;
            if (sign && (mag != '0)) begin
               inv = 1'b1;
            end else begin
               res = mag;
               inx = rem_nz;
            end
         end else if (!is_zero) begin
            inx = 1'b1;
            if (tiny_up) res = INT_W'(1);
            else if (tiny_dn) inv = 1'b1;
         end
      end else begin
         if (is_nan) begin
            inv = 1'b1;
         end else if (big) begin
            res = lim;
            inv = 1'b1;
         end else if (!tiny) begin
            if (mag > lim) begin
               sel = lim;
               inv = 1'b1;
            end else begin
               sel = mag;
               inx = rem_nz;
            end
            res = sign ? (~sel + 1'b1) : sel;
         end else if (!is_zero) begin
            inx = 1'b1;
            if (tiny_up) res = INT_W'(1);
            else if (tiny_dn) res = ONES;
         end
      end
   end
endmodule

// File: rtl/fti_convert.sv
`timescale 1ns/1ps
module fti_convert
   import fti_pkg::*;
#(
   parameter int INT_W        = 32,
   parameter int EXP_W        = 8,
   parameter int FRAC_W       = 23,
   parameter bit CARRY_BY_ADD = 1'b1
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    in_valid,
   input  logic [EXP_W+FRAC_W:0]   operand,
   input  logic                    is_signed,
   input  logic [1:0]              round_mode,
   input  logic                    force_trunc,
   output logic                    out_valid,
   output logic [INT_W-1:0]        result,
   output logic                    flag_invalid,
   output logic                    flag_inexact,
   output logic                    flag_denorm
);
   logic              sign;
   logic [EXP_W-1:0]  exp_f;
   logic [FRAC_W:0]   mant;
   logic              is_nan;
   logic              is_zero;
   logic              is_denorm;
   logic              tiny;
   logic              big;
   logic [INT_W-1:0]  int_part;
   logic [INT_W-1:0]  rem;
   logic              round_up;
   logic              rem_nz;
   logic [INT_W-1:0]  res_c;
   logic              inv_c;
   logic              inx_c;
   rnd_mode_e         mode_eff;

   assign mode_eff = force_trunc ? RND_ZERO : rnd_mode_e'(round_mode);

   fti_classify #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_classify (
      .operand   (operand),
      .sign      (sign),
      .exp_f     (exp_f),
      .mant      (mant),
      .is_nan    (is_nan),
      .is_zero   (is_zero),
      .is_denorm (is_denorm)
   );

   fti_align #(.INT_W(INT_W), .EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_align (
      .exp_f    (exp_f),
      .mant     (mant),
      .tiny     (tiny),
      .big      (big),
      .int_part (int_part),
      .rem      (rem)
   );

   fti_round #(.INT_W(INT_W), .CARRY_BY_ADD(CARRY_BY_ADD)) u_round (
      .rem      (rem),
      .int_lsb  (int_part[0]),
      .sign     (sign),
      .mode     (mode_eff),
      .round_up (round_up),
      .rem_nz   (rem_nz)
   );

   fti_resolve #(.INT_W(INT_W)) u_resolve (
      .sign      (sign),
      .is_nan    (is_nan),
      .is_zero   (is_zero),
      .is_signed (is_signed),
      .tiny      (tiny),
      .big       (big),
      .mode      (mode_eff),
      .int_part  (int_part),
      .round_up  (round_up),
      .rem_nz    (rem_nz),
      .res       (res_c),
      .inv       (inv_c),
      .inx       (inx_c)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid    <= 1'b0;
         result       <= '0;
         flag_invalid <= 1'b0;
         flag_inexact <= 1'b0;
         flag_denorm  <= 1'b0;
      end else begin
         out_valid <= in_valid;
         if (in_valid) begin
            result       <= res_c;
            flag_invalid <= inv_c;
            flag_inexact <= inx_c;
            flag_denorm  <= is_denorm;
         end
      end
   end
endmodule

// File: rtl/fti_convert_chk.sv
`timescale 1ns/1ps
module fti_convert_chk #(
   parameter int INT_W  = 32,
   parameter int EXP_W  = 8,
   parameter int FRAC_W = 23
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic                  in_valid,
   input logic [EXP_W+FRAC_W:0] operand,
   input logic                  is_signed,
   input logic                  out_valid,
   input logic [INT_W-1:0]      result,
   input logic                  flag_invalid,
   input logic                  flag_inexact,
   input logic                  flag_denorm
);
   localparam int FP_W = 1 + EXP_W + FRAC_W;
   localparam logic [INT_W-1:0] SMAX = {1'b0, {(INT_W-1){1'b1}}};
   localparam logic [INT_W-1:0] SMIN = {1'b1, {(INT_W-1){1'b0}}};

   logic op_sign;
   logic op_nan;
   logic op_den;
   logic op_zero;

   assign op_sign = operand[FP_W-1];
   assign op_nan  = (operand[FP_W-2:FRAC_W] == {EXP_W{1'b1}}) && (operand[FRAC_W-1:0] != '0);
   assign op_den  = (operand[FP_W-2:FRAC_W] == '0) && (operand[FRAC_W-1:0] != '0);
   assign op_zero = operand[FP_W-2:0] == '0;

   assert_valid_follows_R1: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid);

   assert_no_spurious_valid_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !out_valid);

   assert_denorm_flag_R2: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> (flag_denorm == $past(op_den)));

   assert_signed_sat_value_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && is_signed) |=>
         (!flag_invalid || result == '0 || result == SMAX || result == SMIN));

   assert_signed_nan_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && is_signed && op_nan) |=> (result == '0 && flag_invalid));

   assert_unsigned_negative_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && !is_signed && op_sign && !op_nan) |=> (result == '0));

   assert_zero_clean_R12: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && op_zero) |=> (result == '0 && !flag_invalid && !flag_inexact));
endmodule

bind fti_convert fti_convert_chk #(
   .INT_W (INT_W),
   .EXP_W (EXP_W),
   .FRAC_W(FRAC_W)
) u_fti_convert_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .in_valid     (in_valid),
   .operand      (operand),
   .is_signed    (is_signed),
   .out_valid    (out_valid),
   .result       (result),
   .flag_invalid (flag_invalid),
   .flag_inexact (flag_inexact),
   .flag_denorm  (flag_denorm)
);

// File: tb/test_fti_convert.sv
`timescale 1ns/1ps
module test_fti_convert;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic [31:0] operand = '0;
   logic        is_signed = 1'b0;
   logic [1:0]  round_mode = '0;
   logic        force_trunc = 1'b0;
   logic        out_valid;
   logic [31:0] result;
   logic        flag_invalid;
   logic        flag_inexact;
   logic        flag_denorm;

   int n_checks = 0;
   int n_fail   = 0;
   bit done     = 0;

   always #10 clk = ~clk;

   fti_convert i_fti_convert (
      .clk          (clk),
      .rst_n        (rst_n),
      .in_valid     (in_valid),
      .operand      (operand),
      .is_signed    (is_signed),
      .round_mode   (round_mode),
      .force_trunc  (force_trunc),
      .out_valid    (out_valid),
      .result       (result),
      .flag_invalid (flag_invalid),
      .flag_inexact (flag_inexact),
      .flag_denorm  (flag_denorm)
   );

   // expected {result, invalid, inexact, denorm}
   function automatic logic [34:0] ref_conv(input logic [31:0] op, input bit sgn,
                                             input logic [1:0] md, input bit trn);
      bit               s = op[31];
      int               e = int'(op[30:23]);
      logic [22:0]      f = op[22:0];
      logic [1:0]       m = trn ? 2'd3 : md;
      logic [31:0]      r = '0;
      bit               inv = 0;
      bit               inx = 0;
      bit               den = (e == 0) && (f != 0);
      longint unsigned  mant, q, rb, half, mag, lim;
      bit               up;
      if (e == 255 && f != 0) begin
         inv = 1;
         r = sgn ? 32'h0 : 32'hFFFFFFFF;
      end else if (e >= 159) begin
         inv = 1;
         if (sgn) r = s ? 32'h80000000 : 32'h7FFFFFFF;
         else     r = s ? 32'h0 : 32'hFFFFFFFF;
      end else if (e < 126) begin
         if (e != 0 || f != 0) begin
            inx = 1;
            if (m == 2'd1 && !s) r = 32'd1;
            else if (m == 2'd2 && s) begin
               if (sgn) r = 32'hFFFFFFFF;
               else inv = 1;
            end
         end
      end else begin
         mant = {40'd0, 1'b1, f};
         if (e >= 150) begin
            q = mant << (e - 150);
            rb = 0;
            half = 1;
         end else begin
            q = mant >> (150 - e);
            rb = mant & ((64'd1 << (150 - e)) - 1);
            half = 64'd1 << (149 - e);
         end
         case (m)
            2'd0:    up = (rb > half) || (rb == half && q[0]);
            2'd1:    up = (rb != 0) && !s;
            2'd2:    up = (rb != 0) && s;
            default: up = 0;
         endcase
         mag = q + longint'(up);
         if (!sgn) begin
            if (s && mag != 0) inv = 1;
            else begin
               r = mag[31:0];
               inx = rb != 0;
            end
         end else begin
            lim = s ? 64'h80000000 : 64'h7FFFFFFF;
            if (mag > lim) begin
               inv = 1;
               r = lim[31:0];
            end else begin
               r = s ? (32'd0 - mag[31:0]) : mag[31:0];
               inx = rb != 0;
            end
         end
      end
      return {r, inv, inx, den};
   endfunction

   task automatic check_out(input string tag, input logic [31:0] exp_r, input logic [2:0] exp_f);
      n_checks++;
      if (result !== exp_r || {flag_invalid, flag_inexact, flag_denorm} !== exp_f) begin
         n_fail++;
         $display("FAIL %s: got result=%h flags(inv,inx,den)=%b, expected result=%h flags=%b",
                  tag, result, {flag_invalid, flag_inexact, flag_denorm}, exp_r, exp_f);
      end
   endtask

   task automatic apply(input logic [31:0] op, input bit sgn, input logic [1:0] md, input bit trn);
      @(negedge clk);
      operand     = op;
      is_signed   = sgn;
      round_mode  = md;
      force_trunc = trn;
      in_valid    = 1'b1;
      @(negedge clk);
      in_valid    = 1'b0;
   endtask

   task automatic conv(input logic [31:0] op, input bit sgn, input logic [1:0] md, input bit trn,
                       input logic [31:0] exp_r, input logic [2:0] exp_f, input string tag);
      apply(op, sgn, md, trn);
      check_out(tag, exp_r, exp_f);
   endtask

   task automatic report();
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
   endtask

   initial begin
      #(20 * 150000);
      if (!done) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: run did not finish, expected completion");
         report();
         $finish;
      end
   end

   initial begin
      logic [34:0] ev;
      void'($urandom(32'd4127));
      repeat (3) @(negedge clk);
      // R13 reset state
      n_checks++;
      if (out_valid !== 1'b0 || result !== 32'h0 ||
          {flag_invalid, flag_inexact, flag_denorm} !== 3'b000) begin
         n_fail++;
         $display("FAIL R13: out_valid=%b result=%h flags=%b expected 0/0/000",
                  out_valid, result, {flag_invalid, flag_inexact, flag_denorm});
      end
      rst_n = 1'b1;

      // R1 timing: valid for one cycle after the request
      apply(32'h3F800000, 1'b1, 2'd0, 1'b0);
      n_checks++;
      if (out_valid !== 1'b1) begin
         n_fail++;
         $display("FAIL R1: out_valid=%b expected 1", out_valid);
      end
      @(negedge clk);
      n_checks++;
      if (out_valid !== 1'b0 || result !== 32'd1) begin
         n_fail++;
         $display("FAIL R1: out_valid=%b result=%h expected 0 and held 00000001", out_valid, result);
      end

      // R5 nearest, ties to even
      conv(32'h3FC00000, 1, 2'd0, 0, 32'd2, 3'b010, "R5 1.5");
      conv(32'h40200000, 1, 2'd0, 0, 32'd2, 3'b010, "R5 2.5");
      conv(32'h40600000, 1, 2'd0, 0, 32'd4, 3'b010, "R5 3.5");
      conv(32'hC0200000, 1, 2'd0, 0, 32'hFFFFFFFE, 3'b010, "R5 -2.5");
      // R6 directed modes
      conv(32'h40200000, 1, 2'd1, 0, 32'd3, 3'b010, "R6 up");
      conv(32'h40200000, 1, 2'd2, 0, 32'd2, 3'b010, "R6 down");
      conv(32'h40200000, 1, 2'd3, 0, 32'd2, 3'b010, "R6 zero");
      conv(32'hC0200000, 1, 2'd2, 0, 32'hFFFFFFFD, 3'b010, "R6 down neg");
      conv(32'hC0200000, 1, 2'd1, 0, 32'hFFFFFFFE, 3'b010, "R6 up neg");
      // R7 truncate override
      conv(32'h40200000, 1, 2'd1, 1, 32'd2, 3'b010, "R7 up forced");
      conv(32'hC0200000, 1, 2'd2, 1, 32'hFFFFFFFE, 3'b010, "R7 down forced");
      // R3 saturation
      conv(32'h7F800000, 0, 2'd0, 0, 32'hFFFFFFFF, 3'b100, "R3 +inf u");
      conv(32'h7F800000, 1, 2'd0, 0, 32'h7FFFFFFF, 3'b100, "R3 +inf s");
      conv(32'hFF800000, 1, 2'd0, 0, 32'h80000000, 3'b100, "R3 -inf s");
      conv(32'hFF800000, 0, 2'd0, 0, 32'h00000000, 3'b100, "R3 -inf u");
      conv(32'h4F800000, 0, 2'd0, 0, 32'hFFFFFFFF, 3'b100, "R3 2^32 u");
      // R4 NaN
      conv(32'h7FC00000, 1, 2'd0, 0, 32'h0, 3'b100, "R4 nan s");
      conv(32'h7FC00000, 0, 2'd0, 0, 32'hFFFFFFFF, 3'b100, "R4 nan u");
      conv(32'hFFC00001, 0, 2'd2, 0, 32'hFFFFFFFF, 3'b100, "R4 -nan u");
      // R8 unsigned negative
      conv(32'hBF800000, 0, 2'd0, 0, 32'h0, 3'b100, "R8 -1.0 u");
      conv(32'hBF333333, 0, 2'd3, 0, 32'h0, 3'b010, "R8 -0.7 u");
      // R9 signed overflow
      conv(32'h4F000000, 1, 2'd0, 0, 32'h7FFFFFFF, 3'b100, "R9 2^31");
      conv(32'hCF000000, 1, 2'd0, 0, 32'h80000000, 3'b000, "R9 -2^31");
      conv(32'h4EFFFFFF, 1, 2'd1, 0, 32'h7FFFFF80, 3'b000, "R9 max float");
      // R10 exactness
      conv(32'h3F800000, 0, 2'd0, 0, 32'd1, 3'b000, "R10 1.0");
      conv(32'h3FA00000, 0, 2'd3, 0, 32'd1, 3'b010, "R10 1.25");
      conv(32'h4F7FFFFF, 0, 2'd0, 0, 32'hFFFFFF00, 3'b000, "R10 large u");
      // R11 sub-half magnitudes
      conv(32'h3E800000, 0, 2'd1, 0, 32'd1, 3'b010, "R11 0.25 up");
      conv(32'hBE800000, 1, 2'd2, 0, 32'hFFFFFFFF, 3'b010, "R11 -0.25 down s");
      conv(32'hBE800000, 0, 2'd2, 0, 32'h0, 3'b110, "R11 -0.25 down u");
      conv(32'h3E800000, 1, 2'd0, 0, 32'h0, 3'b010, "R11 0.25 nearest");
      conv(32'h3F400000, 1, 2'd0, 0, 32'd1, 3'b010, "R11 0.75 nearest");
      // R2 denormal
      conv(32'h00000001, 1, 2'd0, 0, 32'h0, 3'b011, "R2 denorm");
      conv(32'h00000001, 0, 2'd1, 0, 32'd1, 3'b011, "R2 denorm up");
      // R12 zeros
      conv(32'h00000000, 1, 2'd1, 0, 32'h0, 3'b000, "R12 +0");
      conv(32'h80000000, 0, 2'd2, 0, 32'h0, 3'b000, "R12 -0");

      // constrained random against the bench model (R5 R6 R10)
      for (int i = 0; i < 4000; i++) begin
         logic [31:0] op;
         logic [7:0]  ex;
         bit          sg;
         logic [1:0]  md;
         bit          tr;
         op = $urandom;
         case ($urandom_range(0, 3))
            0: ex = op[30:23];
            1: ex = 8'($urandom_range(118, 166));
            2: ex = 8'($urandom_range(148, 160));
            default: ex = ($urandom_range(0, 1) == 1) ? 8'hFF : 8'h00;
         endcase
         op[30:23] = ex;
         sg = 1'($urandom_range(0, 1));
         md = 2'($urandom_range(0, 3));
         tr = ($urandom_range(0, 7) == 0);
         ev = ref_conv(op, sg, md, tr);
         apply(op, sg, md, tr);
         check_out($sformatf("R10 random op=%h s=%0d m=%0d t=%0d", op, sg, md, tr),
                   ev[34:3], ev[2:0]);
      end

      done = 1;
      report();
      $finish;
   end
endmodule